// File: doc/BRIEF.md
# Phase Error Detector and Integrator

This block sits in the digital carrier-tracking path of a receiver. On every sampling cycle it compares the sign bit of the incoming sample with one phase of the local reference. It then steps a signed integrator up by one when the two bits agree and down by one when they disagree. The agreement test is a single exclusive-NOR. The integrator is a chain of per-bit toggle stages. A ripple of full-adder cells computes the effective plus-one or minus-one step and tells each stage whether to flip.

A host processor reads the accumulated phase error by pulsing a dump strobe. In that cycle the integrator's value, including any sample that arrives in the same cycle, is copied into a parallel-load shift register, and the integrator restarts from zero. The host then clocks the word out serially, most significant bit first, one bit for each shift enable. A ready flag stays high while unread bits remain.

Top module: `ped_phase_integrator`

## Requirements
- R1: After synchronous reset, `ready` is 0 and `ser_out` is 0, and the integrator holds 0, so a dump right after reset reads back the value 0.
- R2: A sampling cycle (`sample_en`=1) in which `in_sign` equals `ref_bit` (comparator output 1, "agree") adds +1 to the integrator.
- R3: A sampling cycle in which `in_sign` differs from `ref_bit` (comparator output 0, "disagree") adds -1 to the integrator.
- R4: The integrator is ACC_W bits wide (18 by default) and wraps in two's complement: -1 reads back as 0x3FFFF, and 131071 plus one reads back as 0x20000.
- R5: When `sample_en` is 0 the integrator does not change, whatever `in_sign` and `ref_bit` do.
- R6: When `dump` is 1, the shift register loads the integrator value, including that cycle's sample if `sample_en` is also 1, and the integrator clears to 0 in the same cycle. No sample is lost and none is counted twice.
- R7: After a load, `ready` is 1 and `ser_out` presents bit ACC_W-1. Each `shift_en` cycle moves the next lower bit onto `ser_out`. `ready` falls on exactly the ACC_W-th shift.
- R8: `shift_en` while `ready` is 0 has no effect, and `ser_out` stays 0 while `ready` is 0.
- R9: `dump` has priority over `shift_en`: a dump during a readout discards the remaining bits and restarts the readout with the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Marks a cycle that carries a new sample |
| in_sign | input | 1 | Sign bit of the incoming sample |
| ref_bit | input | 1 | Local reference phase bit |
| dump | input | 1 | Snapshot the integrator into the shift register and clear it |
| shift_en | input | 1 | Advance the serial readout by one bit |
| ser_out | output | 1 | Serial data, most significant bit first |
| ready | output | 1 | High while unread bits remain in the shift register |

## Verification
All four combinations of sample sign and reference bit are applied so that exclusive-NOR agreement is told apart from a plain equality on either input alone. Runs of pure agreement, pure disagreement and interleaved patterns separate the +1 and -1 step paths through the adder ripple. Wrap-around is reached from both sides: zero minus one exposes the borrow chain, and a long positive run up to the top value exposes the carry chain. A dump that coincides with a sample shows whether the boundary sample lands in exactly one of the two integration windows. Dumps issued in the middle of a readout check the ordering between the readout and a new snapshot.

// File: rtl/ped_pkg.sv
package ped_pkg;

    localparam int unsigned PED_ACC_W = 18;

    typedef enum logic {
        CMP_DISAGREE = 1'b0,
        CMP_AGREE    = 1'b1
    } cmp_e;

    typedef struct packed {
        logic valid;
        cmp_e dir;
    } step_t;

    function automatic cmp_e phase_xnor(input logic a, input logic b);
        return cmp_e'(~(a ^ b));
    endfunction

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/ped_comparator.sv
module ped_comparator
    import ped_pkg::*;
(
    input  logic  sample_en,
    input  logic  in_sign,
    input  logic  ref_bit,
    output step_t step
);

    always_comb begin
        step.valid = sample_en;
        step.dir   = phase_xnor(in_sign, ref_bit);
    end

endmodule

// File: rtl/ped_integrator.sv
module ped_integrator
    import ped_pkg::*;
#(
    parameter int unsigned ACC_W = PED_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic             dump,
    output logic [ACC_W-1:0] snapshot
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend;
    logic [ACC_W:0]   carry;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] flip;

    // +1 is 0...01, -1 is 1...11: bit 0 is always 1, upper bits follow the direction
    assign addend[0] = 1'b1;
    assign carry[0]  = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < ACC_W; gi++) begin : g_stage
            if (gi > 0) begin : g_hi
                assign addend[gi] = (step.dir == CMP_DISAGREE);
            end
            assign sum[gi]      = fa_sum(acc_q[gi], addend[gi], carry[gi]);
            assign carry[gi+1]  = fa_carry(acc_q[gi], addend[gi], carry[gi]);
            // toggle stage: flip only when a sample arrives and the sum differs
            assign flip[gi]     = step.valid & (sum[gi] ^ acc_q[gi]);
            assign snapshot[gi] = acc_q[gi] ^ flip[gi];

            always_ff @(posedge clk) begin
                if (rst || dump) begin
                    acc_q[gi] <= 1'b0;
                end else if (flip[gi]) begin
                    acc_q[gi] <= ~acc_q[gi];
                end
            end
        end
    endgenerate

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(step.valid) && $past(step.dir) == CMP_AGREE && !$past(dump))
            |-> acc_q == $past(acc_q) + ACC_W'(1));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(step.valid) && $past(step.dir) == CMP_DISAGREE && !$past(dump))
            |-> acc_q == $past(acc_q) - ACC_W'(1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(step.valid) && !$past(dump)) |-> $stable(acc_q));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $past(dump) |-> acc_q == '0);

endmodule

// File: rtl/ped_shifter.sv
module ped_shifter #(
    parameter int unsigned ACC_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    input  logic             shift_en,
    output logic             ser_out,
    output logic             ready
);

    localparam int unsigned CNT_W = $clog2(ACC_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ACC_W);

    logic [ACC_W-1:0] sr_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sr_q   <= load_val;
            left_q <= FULL;
        end else if (shift_en && left_q != '0) begin
            sr_q   <= {sr_q[ACC_W-2:0], 1'b0};
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign ser_out = sr_q[ACC_W-1];
    assign ready   = (left_q != '0);

    assert_load_ready_R7: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> ready && ser_out == $past(load_val[ACC_W-1]));

    assert_fall_last_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(shift_en) && $past(left_q) == CNT_W'(1));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !ser_out);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(ready) && !$past(load)) |-> $stable(sr_q));

endmodule

// File: rtl/ped_phase_integrator.sv
module ped_phase_integrator
    import ped_pkg::*;
#(
    parameter int unsigned ACC_W = PED_ACC_W
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic in_sign,
    input  logic ref_bit,
    input  logic dump,
    input  logic shift_en,
    output logic ser_out,
    output logic ready
);

    step_t            step;
    logic [ACC_W-1:0] snapshot;

    ped_comparator u_cmp (
        .sample_en (sample_en),
        .in_sign   (in_sign),
        .ref_bit   (ref_bit),
        .step      (step)
    );

    ped_integrator #(.ACC_W(ACC_W)) u_int (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .dump     (dump),
        .snapshot (snapshot)
    );

    ped_shifter #(.ACC_W(ACC_W)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .load     (dump),
        .load_val (snapshot),
        .shift_en (shift_en),
        .ser_out  (ser_out),
        .ready    (ready)
    );

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !ready && !ser_out);

endmodule

// File: tb/ped_phase_integrator_tb_top.sv
module ped_phase_integrator_tb_top;

    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic in_sign = 1'b0;
    logic ref_bit = 1'b0;
    logic dump = 1'b0;
    logic shift_en = 1'b0;
    logic ser_out;
    logic ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ped_phase_integrator #(.ACC_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .in_sign   (in_sign),
        .ref_bit   (ref_bit),
        .dump      (dump),
        .shift_en  (shift_en),
        .ser_out   (ser_out),
        .ready     (ready)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
        end
    endtask

    task automatic samples(int n, logic s, logic r);
        @(negedge clk);
        sample_en = 1'b1; in_sign = s; ref_bit = r;
        for (int i = 0; i < n; i++) @(negedge clk);
        sample_en = 1'b0;
    endtask

    task automatic do_dump(logic with_sample, logic s, logic r);
        @(negedge clk);
        dump = 1'b1; sample_en = with_sample; in_sign = s; ref_bit = r;
        @(negedge clk);
        dump = 1'b0; sample_en = 1'b0;
    endtask

    // reads all bits, MSB first; checks ready during and after
    task automatic read_word(string req, logic [W-1:0] exp);
        logic [W-1:0] v = '0;
        int ready_bad = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (ready !== 1'b1) ready_bad++;
            v[i] = ser_out;
            shift_en = 1'b1;
            @(negedge clk);
            shift_en = 1'b0;
        end
        check(req, v, exp);
        check({req, " R7 ready during readout"}, W'(ready_bad), W'(0));
        check({req, " R7 ready low after last shift"}, W'(ready), W'(0));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready after reset", W'(ready), W'(0));
        check("R1 ser_out after reset", W'(ser_out), W'(0));
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R1 integrator zero", W'(0));
    endtask

    task automatic t_combos;
        samples(1, 1'b0, 1'b0);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R2 agree 0/0", W'(1));
        samples(1, 1'b1, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R2 agree 1/1", W'(1));
        samples(1, 1'b0, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R3 disagree 0/1 wraps R4", 18'h3FFFF);
        samples(1, 1'b1, 1'b0);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R3 disagree 1/0", 18'h3FFFF);
    endtask

    task automatic t_runs;
        samples(5, 1'b1, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R2 run of 5 agree", W'(5));
        samples(3, 1'b0, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R3 run of 3 disagree", 18'h3FFFD);
        for (int k = 0; k < 9; k++) samples(1, (k % 3) != 0 ? 1'b1 : 1'b0, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R2 R3 interleaved 6 up 3 down", W'(3));
    endtask

    task automatic t_hold;
        samples(4, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_sign = k[0]; ref_bit = k[1];
        end
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R5 no change without sample_en", W'(4));
    endtask

    task automatic t_dump_edge;
        samples(2, 1'b1, 1'b1);
        do_dump(1'b1, 1'b1, 1'b1);
        read_word("R6 boundary sample in snapshot", W'(3));
        samples(1, 1'b1, 1'b1);
        do_dump(1'b1, 1'b0, 1'b1);
        read_word("R6 cleared then +1 -1", W'(0));
    endtask

    task automatic t_idle_shift;
        samples(2, 1'b1, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R7 readout", W'(2));
        @(negedge clk);
        shift_en = 1'b1;
        repeat (5) @(negedge clk);
        shift_en = 1'b0;
        check("R8 ready stays low", W'(ready), W'(0));
        check("R8 ser_out stays 0", W'(ser_out), W'(0));
        samples(7, 1'b1, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        read_word("R8 state intact after idle shifts", W'(7));
    endtask

    task automatic t_override;
        samples(1, 1'b0, 1'b1);
        do_dump(1'b0, 1'b0, 1'b0);
        // shift part way through the -1 word, then dump a new value with shift_en high
        for (int i = 0; i < 5; i++) begin
            shift_en = 1'b1; @(negedge clk); shift_en = 1'b0;
        end
        samples(6, 1'b1, 1'b1);
        @(negedge clk);
        dump = 1'b1; shift_en = 1'b1;
        @(negedge clk);
        dump = 1'b0; shift_en = 1'b0;
        read_word("R9 dump overrides shift", W'(6));
    endtask

    task automatic t_wrap;
        samples(131071, 1'b1, 1'b1);
        do_dump(1'b1, 1'b1, 1'b1);
        read_word("R4 positive wrap", 18'h20000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_combos();
        t_runs();
        t_hold();
        t_dump_edge();
        t_idle_shift();
        t_override();
        t_wrap();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule